// File: doc/BRIEF.md
# Keyed-Lock Two-Stage Watchdog Timer

This block is a watchdog peripheral on a plain 32-bit register bus. It has a 32-bit down-counter that advances on a core tick enable. The first expiry raises an interrupt and restarts the count from the load value. A second expiry that arrives before software has cleared the interrupt asks for a system reset, when reset is enabled. The effective reset timeout is therefore about twice the programmed load period.

All registers except the lock register are protected. While the block is locked, bus writes to them are dropped. Software unlocks the block by writing a 32-bit key. It then reprograms the load value, sets the enables, or services the watchdog by writing the clear register. The clear write drops the interrupt and restarts the count. Reads are combinational from the address and are always allowed.

The bus here is a register interface, not a data stream. It has no valid/ready handshake and no back-pressure: a write takes effect at the clock edge where `bus_sel` and `bus_we` are both high.

Top module: `kwd_watchdog`

## Requirements
- R1: After reset the lock register reads 1, the load register reads 0xFFFFFFFF, the control register reads 0, and `irq` and `sys_rst_req` are low.
- R2: Writing 0x1ACCE551 to the lock register (byte offset 0xC00) makes it read 0. Writing any other value makes it read 1 again.
- R3: While the block is locked, writes to load (0x000), control (0x008) and interrupt clear (0x00C) have no effect.
- R4: Control bit 0 enables the reset request and bit 1 enables the counter and interrupt. Bits 31:2 read as zero whatever was written.
- R5: One clock after control bit 1 rises, the count register (0x004) holds the load value. After that the count drops by one on each cycle with `tick_en` high, and holds when `tick_en` is low.
- R6: A tick that finds the count at zero with no interrupt pending sets the interrupt and reloads the count from the load value. This happens on the (load+1)-th tick after a load.
- R7: An unlocked write of any value to the interrupt clear register clears the pending interrupt and reloads the count from the load value.
- R8: A tick that finds the count at zero while the interrupt is pending and control bit 0 is set produces `sys_rst_req` high for exactly one clock. After that the block stays halted: the count is frozen and no further pulse occurs until reset.
- R9: The same second expiry with control bit 0 clear produces no reset request. The count reloads and the interrupt stays pending.
- R10: The status register (0x014) reads 1, and `irq` is high, only while the interrupt is pending and control bit 1 is set. Clearing bit 1 masks both without dropping the pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Core tick enable; the counter advances on cycles where it is high |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for `bus_sel` |
| bus_addr | input | 12 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt, pending and enabled |
| sys_rst_req | output | 1 | Single-cycle system reset request |

## Verification
The hardest state to reach is the second expiry with reset enabled. It needs a full load period to raise the interrupt and then a second full period with the interrupt left uncleared. After it fires, the block halts for good. The stimulus uses a load value of 5 and drives `tick_en` in counted bursts, so every expiry lands on a known tick. It first runs the same second expiry with reset disabled, so the reload path is covered. It then sets the reset enable while the interrupt is still pending, counts the pulses, and applies further ticks to show the count stays frozen.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int KWD_DW = 32;
  localparam int KWD_AW = 12;

  localparam logic [KWD_AW-1:0] OFS_LOAD  = 12'h000;
  localparam logic [KWD_AW-1:0] OFS_COUNT = 12'h004;
  localparam logic [KWD_AW-1:0] OFS_CTRL  = 12'h008;
  localparam logic [KWD_AW-1:0] OFS_ICLR  = 12'h00C;
  localparam logic [KWD_AW-1:0] OFS_STAT  = 12'h014;
  localparam logic [KWD_AW-1:0] OFS_LOCK  = 12'hC00;

  localparam logic [KWD_DW-1:0] UNLOCK_KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic run_en;
    logic rst_en;
  } kwd_ctrl_t;
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int DW = KWD_DW,
  parameter int AW = KWD_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] cnt_val,
  input  logic          irq_stat,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] load_val,
  output kwd_ctrl_t     ctrl,
  output logic          clr_pulse
);
  localparam int PADW = DW - 2;

  logic locked;
  logic wr;
  logic wr_open;

  assign wr      = bus_sel & bus_we;
  assign wr_open = wr & ~locked;
  assign clr_pulse = wr_open && (bus_addr == OFS_ICLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b1;
      load_val <= '1;
      ctrl     <= '0;
    end else begin
      if (wr && bus_addr == OFS_LOCK)
        locked <= (bus_wdata != UNLOCK_KEY);
      if (wr_open && bus_addr == OFS_LOAD)
        load_val <= bus_wdata;
      if (wr_open && bus_addr == OFS_CTRL) begin
        ctrl.rst_en <= bus_wdata[0];
        ctrl.run_en <= bus_wdata[1];
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_LOAD:  bus_rdata = load_val;
      OFS_COUNT: bus_rdata = cnt_val;
      OFS_CTRL:  bus_rdata = {{PADW{1'b0}}, ctrl.run_en, ctrl.rst_en};
      OFS_STAT:  bus_rdata = {{(DW-1){1'b0}}, irq_stat};
      OFS_LOCK:  bus_rdata = {{(DW-1){1'b0}}, locked};
      default:   bus_rdata = '0;
    endcase
  end

  // R3
  locked_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr && bus_addr == OFS_LOAD) |=> $stable(load_val));

  // R3
  locked_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr && bus_addr == OFS_CTRL) |=> $stable(ctrl));

  // R2
  key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_LOCK && bus_wdata == UNLOCK_KEY) |=> !locked);
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          run_en,
  input  logic          rst_en,
  input  logic [DW-1:0] load_val,
  input  logic          clr_pulse,
  output logic [DW-1:0] cnt_val,
  output logic          irq_pend,
  output logic          rst_req,
  output logic          halted
);
  logic run_q;
  logic start;
  logic at_zero;

  assign start   = run_en & ~run_q;
  assign at_zero = (cnt_val == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_val  <= '1;
      irq_pend <= 1'b0;
      rst_req  <= 1'b0;
      halted   <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      run_q   <= run_en;
      rst_req <= 1'b0;
      if (halted) begin
        cnt_val <= cnt_val;
      end else if (clr_pulse) begin
        irq_pend <= 1'b0;
        cnt_val  <= load_val;
      end else if (start) begin
        cnt_val <= load_val;
      end else if (run_en && tick_en) begin
        if (!at_zero) begin
          cnt_val <= cnt_val - 1'b1;
        end else if (!irq_pend) begin
          irq_pend <= 1'b1;
          cnt_val  <= load_val;
        end else if (rst_en) begin
          rst_req <= 1'b1;
          halted  <= 1'b1;
        end else begin
          cnt_val <= load_val;
        end
      end
    end
  end

  // R8
  rst_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R8
  halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(cnt_val) && !rst_req));

  // R8
  rst_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(irq_pend) && $past(rst_en)));

  // R7
  clear_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !halted) |=> (!irq_pend && cnt_val == $past(load_val)));
endmodule

// File: rtl/kwd_watchdog.sv
module kwd_watchdog
  import kwd_pkg::*;
#(
  parameter int DW = KWD_DW,
  parameter int AW = KWD_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          sys_rst_req
);
  logic [DW-1:0] load_val;
  logic [DW-1:0] cnt_val;
  kwd_ctrl_t     ctrl;
  logic          clr_pulse;
  logic          irq_pend;
  logic          halted;

  assign irq = irq_pend & ctrl.run_en;

  kwd_regs #(.DW(DW), .AW(AW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_val   (cnt_val),
    .irq_stat  (irq),
    .bus_rdata (bus_rdata),
    .load_val  (load_val),
    .ctrl      (ctrl),
    .clr_pulse (clr_pulse)
  );

  kwd_counter #(.DW(DW)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .run_en    (ctrl.run_en),
    .rst_en    (ctrl.rst_en),
    .load_val  (load_val),
    .clr_pulse (clr_pulse),
    .cnt_val   (cnt_val),
    .irq_pend  (irq_pend),
    .rst_req   (sys_rst_req),
    .halted    (halted)
  );

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl.run_en);
endmodule

// File: tb/kwd_watchdog_tb_top.sv
`timescale 1ns/1ps
module kwd_watchdog_tb_top;
  import kwd_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        sys_rst_req;

  int n_vec = 0;
  int n_bad = 0;
  int rst_pulses = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  kwd_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sys_rst_req(sys_rst_req)
  );

  always @(posedge clk) if (rst_n && sys_rst_req) rst_pulses++;

  // monitor: pops the expected item and compares with the observed value
  task automatic monitor_cmp(input logic [31:0] act);
    logic [31:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    n_vec++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  // driver side: push the expectation, then present the observation
  task automatic expect_val(input string t, input logic [31:0] e, input logic [31:0] act);
    exp_q.push_back(e);
    tag_q.push_back(t);
    monitor_cmp(act);
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic chk_rd(input string t, input logic [11:0] a, input logic [31:0] e);
    bus_addr = a;
    #1;
    expect_val(t, e, bus_rdata);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk_rd("R1 lock", OFS_LOCK, 32'd1);
    chk_rd("R1 load", OFS_LOAD, 32'hFFFF_FFFF);
    chk_rd("R1 ctrl", OFS_CTRL, 32'd0);
    expect_val("R1 irq", 32'd0, {31'd0, irq});
    expect_val("R1 rst_req", 32'd0, {31'd0, sys_rst_req});

    // R3 writes ignored while locked
    bus_wr(OFS_LOAD, 32'd5);
    chk_rd("R3 load locked", OFS_LOAD, 32'hFFFF_FFFF);
    bus_wr(OFS_CTRL, 32'd3);
    chk_rd("R3 ctrl locked", OFS_CTRL, 32'd0);

    // R2 key handling
    bus_wr(OFS_LOCK, UNLOCK_KEY);
    chk_rd("R2 unlocked", OFS_LOCK, 32'd0);
    bus_wr(OFS_LOCK, 32'h0000_1234);
    chk_rd("R2 relocked", OFS_LOCK, 32'd1);
    bus_wr(OFS_LOCK, UNLOCK_KEY);

    // R4 control fields
    bus_wr(OFS_CTRL, 32'hFFFF_FFF0);
    chk_rd("R4 reserved zero", OFS_CTRL, 32'd0);
    bus_wr(OFS_CTRL, 32'hFFFF_FFFD);
    chk_rd("R4 rst_en only", OFS_CTRL, 32'd1);
    bus_wr(OFS_CTRL, 32'd0);
    bus_wr(OFS_LOAD, 32'd5);
    chk_rd("R3 load unlocked", OFS_LOAD, 32'd5);

    // R5 start and count
    bus_wr(OFS_CTRL, 32'd2);
    idle(1);
    chk_rd("R5 start load", OFS_COUNT, 32'd5);
    ticks(1);
    chk_rd("R5 decrement", OFS_COUNT, 32'd4);
    idle(3);
    chk_rd("R5 hold no tick", OFS_COUNT, 32'd4);
    ticks(4);
    chk_rd("R5 reach zero", OFS_COUNT, 32'd0);
    expect_val("R6 no irq at zero", 32'd0, {31'd0, irq});

    // R6 first expiry
    ticks(1);
    expect_val("R6 irq raised", 32'd1, {31'd0, irq});
    chk_rd("R6 reload", OFS_COUNT, 32'd5);
    chk_rd("R6 status", OFS_STAT, 32'd1);

    // R10 masking by counter enable
    bus_wr(OFS_CTRL, 32'd0);
    chk_rd("R10 status masked", OFS_STAT, 32'd0);
    expect_val("R10 irq masked", 32'd0, {31'd0, irq});
    bus_wr(OFS_CTRL, 32'd2);
    idle(1);
    chk_rd("R10 pending kept", OFS_STAT, 32'd1);

    // R9 second expiry without reset enable
    ticks(6);
    chk_rd("R9 reload", OFS_COUNT, 32'd5);
    expect_val("R9 irq still", 32'd1, {31'd0, irq});
    expect_val("R9 no reset", 32'd0, rst_pulses);

    // R7 clear
    ticks(2);
    chk_rd("R7 pre", OFS_COUNT, 32'd3);
    bus_wr(OFS_ICLR, 32'hDEAD_BEEF);
    chk_rd("R7 reload", OFS_COUNT, 32'd5);
    expect_val("R7 irq cleared", 32'd0, {31'd0, irq});

    // R3 clear ignored while locked
    ticks(6);
    expect_val("R6 irq again", 32'd1, {31'd0, irq});
    bus_wr(OFS_LOCK, 32'd0);
    bus_wr(OFS_ICLR, 32'd1);
    expect_val("R3 clear ignored", 32'd1, {31'd0, irq});
    bus_wr(OFS_LOAD, 32'd9);
    chk_rd("R3 load ignored", OFS_LOAD, 32'd5);
    bus_wr(OFS_LOCK, UNLOCK_KEY);

    // R8 second expiry with reset enable
    bus_wr(OFS_CTRL, 32'd3);
    chk_rd("R8 count kept", OFS_COUNT, 32'd5);
    ticks(5);
    expect_val("R8 no early reset", 32'd0, rst_pulses);
    ticks(1);
    expect_val("R8 pulse high", 32'd1, {31'd0, sys_rst_req});
    idle(1);
    expect_val("R8 pulse low", 32'd0, {31'd0, sys_rst_req});
    ticks(10);
    expect_val("R8 single pulse", 32'd1, rst_pulses);
    chk_rd("R8 halted count", OFS_COUNT, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule